// File: doc/BRIEF.md
# Stretchable Data-Memory Access Sequencer

This block runs the data-memory move accesses of a small 8-bit core whose machine cycle is four clocks long. When the core raises a request, the sequencer latches the address, direction and write byte. It then sends the access either to a 1 KB on-chip RAM window at the bottom of data space or out to a multiplexed external bus.

On the external bus, one 8-bit port first carries the low address byte while an address latch enable pulse is high. The same port then carries data: it is driven on writes and released on reads. A second port holds the high address byte for the whole access. A 3-bit stretch setting fixes the external access length anywhere from 2 to 9 machine cycles. When wait-state control is on, an external hold input can add further machine cycles. Accesses to the on-chip window take a fixed two machine cycles and leave the bus quiet. Every access ends with a one-clock done pulse to the core.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: After reset, `ale` and `ad_oe` are 0, `rd_n` and `wr_n` are 1, `ad_out` and `addr_hi` are 0, `done` is 0 and `rdata` is 0.
- R2: A request accepted while idle, with stretch value n, occupies (n+2)*4 clocks. `done` is high for exactly one clock, in the clock right after the last access clock.
- R3: During the first machine cycle of an external access, `ale` is 1, `ad_oe` is 1 and `ad_out` carries address bits 7:0. `addr_hi` carries address bits 15:8 for the whole external access. Outside external accesses `ale` is 0 and `addr_hi` and `ad_out` are 0.
- R4: An external write holds `wr_n` low from the second machine cycle through the last one, with `ad_oe` 1 and `ad_out` equal to the write byte. `rd_n` stays 1.
- R5: An external read holds `rd_n` low from the second machine cycle through the last one, with `ad_oe` 0 and `ad_out` 0. `rdata` takes the value of `ad_in` sampled at the clock edge where `rd_n` returns high, and holds it until the next read.
- R6: With `wait_en` 1, if `wait_in` is 1 at the last clock of the last scheduled machine cycle, the access grows by one machine cycle. The same test repeats at the last clock of each added cycle. The strobe stays low throughout.
- R7: With `wait_en` 0, `wait_in` has no effect on access length.
- R8: With `ram_en` 1, addresses below 0x0400 go to on-chip RAM. The access takes 8 clocks regardless of stretch and wait. `ale`, `ad_oe` stay 0 and `rd_n`, `wr_n` stay 1. A read returns the byte last written there.
- R9: With `ram_en` 0, addresses below 0x0400 are external accesses, and on-chip RAM contents are left unchanged.
- R10: With `ram_en` 1, address 0x03FF is on-chip and 0x0400 is external.
- R11: A request is accepted only while idle. Request inputs that change during an access do not affect it. A request held high through `done` is accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request from the core |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Data-space address |
| req_wdata | input | 8 | Write byte |
| stretch | input | 3 | External length: value n gives n+2 machine cycles |
| ram_en | input | 1 | Enables the on-chip 1 KB window |
| wait_en | input | 1 | Enables wait-state control |
| wait_in | input | 1 | Active-high hold from slow external devices |
| ad_in | input | 8 | Multiplexed port, input side |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Multiplexed port, output side (low address, then write data) |
| ad_oe | output | 1 | Output enable of the multiplexed port |
| addr_hi | output | 8 | High address byte |
| rdata | output | 8 | Last read byte |
| done | output | 1 | One-clock completion pulse |

## Verification
External writes and reads are run at the shortest, a middle and the longest stretch. These runs separate a correct stretch decode from an off-by-one in cycle count, and show the strobe direction and port drive for each direction. A hold released part-way through a cycle and a hold ignored because wait control is off show apart correct and wrong wait sampling. The window runs use 0x03FF against 0x0400 and the same address with the window on and off. They tell apart the RAM path from the bus path and show that bus writes leave on-chip bytes alone. A request held high through a busy access, with its address changed mid-access, shows that inputs are latched and that accepts happen only while idle.

// File: rtl/xmem_pkg.sv
// Shared types for the data-memory access sequencer.
package xmem_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_EXT  = 2'd1,
        ACC_INT  = 2'd2
    } acc_state_e;
endpackage

// File: rtl/xmem_mc_timer.sv
// Machine-cycle timer: counts clock phases within a machine cycle and the
// machine-cycle index within an access. Assumes start and run never overlap
// with a stale count; on hold at the final phase the index is kept so the
// last cycle repeats.
module xmem_mc_timer #(
    parameter int CLK_PER_MC = 4,
    parameter int MC_W       = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            run,
    input  logic            hold,
    input  logic [MC_W-1:0] last_mc,
    output logic [MC_W-1:0] mc,
    output logic            acc_end
);
    localparam int PH_W = (CLK_PER_MC > 1) ? $clog2(CLK_PER_MC) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_PER_MC - 1);

    logic [PH_W-1:0] ph;
    logic            mc_end;

    assign mc_end  = (ph == PH_LAST);
    assign acc_end = run && mc_end && (mc == last_mc) && !hold;

    // Advance phase and machine-cycle index.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            ph <= '0;
            mc <= '0;
        end else if (run) begin
            if (mc_end) begin
                ph <= '0;
                if (mc != last_mc) mc <= mc + 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end
endmodule

// File: rtl/xmem_window_ram.sv
// On-chip data RAM window: synchronous write, combinational read.
// Assumes the caller only writes at the completion edge of an access.
module xmem_window_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store a byte on write.
    always_ff @(posedge clk) begin
        if (wr) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/xmem_bus_drive.sv
// External bus pin driver: derives ALE, strobes and port drive from the
// current machine-cycle index. Pure combinational; assumes mc is 0 in the
// first machine cycle of each access.
module xmem_bus_drive #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int MC_W   = 4
) (
    input  logic                 ext,
    input  logic                 we,
    input  logic [MC_W-1:0]      mc,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic                 ale,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 ad_oe,
    output logic [DATA_W-1:0]    ad_out,
    output logic [ADDR_W-DATA_W-1:0] addr_hi
);
    logic first_mc;

    // Decode pin levels from phase of the access.
    always_comb begin
        first_mc = (mc == '0);
        ale      = ext && first_mc;
        rd_n     = !(ext && !first_mc && !we);
        wr_n     = !(ext && !first_mc && we);
        ad_oe    = ext && (first_mc || we);
        addr_hi  = ext ? addr[ADDR_W-1:DATA_W] : '0;
        if (!ext)          ad_out = '0;
        else if (first_mc) ad_out = addr[DATA_W-1:0];
        else if (we)       ad_out = wdata;
        else               ad_out = '0;
    end
endmodule

// File: rtl/xmem_stretch_ctrl.sv
// Data-memory access sequencer top. Accepts one request while idle, routes
// it to the on-chip window or the external multiplexed bus, times it in
// machine cycles and pulses done on completion. Assumes requests come from
// a single core and inputs are synchronous to clk.
module xmem_stretch_ctrl #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int RAM_DEPTH  = 1024,
    parameter int STRETCH_W  = 3,
    parameter int CLK_PER_MC = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req,
    input  logic                     req_we,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [STRETCH_W-1:0]     stretch,
    input  logic                     ram_en,
    input  logic                     wait_en,
    input  logic                     wait_in,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        rdata,
    output logic                     done
);
    import xmem_pkg::*;

    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam int MC_W   = STRETCH_W + 1;
    localparam logic [MC_W-1:0] INT_LAST = MC_W'(1);

    acc_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              we_q;
    logic [MC_W-1:0]   last_q;
    logic [MC_W-1:0]   mc;
    logic              accept, hold, acc_end, in_window;
    logic [DATA_W-1:0] ram_q;

    assign accept    = (state == ACC_IDLE) && req;
    assign in_window = ram_en && (req_addr[ADDR_W-1:RAM_AW] == '0);
    assign hold      = (state == ACC_EXT) && wait_en && wait_in;

    // Access state, latched request and completion results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ACC_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
            last_q  <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                state   <= in_window ? ACC_INT : ACC_EXT;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                we_q    <= req_we;
                last_q  <= in_window ? INT_LAST : ({1'b0, stretch} + 1'b1);
            end else if (acc_end) begin
                state <= ACC_IDLE;
                done  <= 1'b1;
                if (!we_q) rdata <= (state == ACC_INT) ? ram_q : ad_in;
            end
        end
    end

    xmem_mc_timer #(.CLK_PER_MC(CLK_PER_MC), .MC_W(MC_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (accept),
        .run     (state != ACC_IDLE),
        .hold    (hold),
        .last_mc (last_q),
        .mc      (mc),
        .acc_end (acc_end)
    );

    xmem_window_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
        .clk   (clk),
        .wr    ((state == ACC_INT) && acc_end && we_q),
        .addr  (addr_q[RAM_AW-1:0]),
        .wdata (wdata_q),
        .rdata (ram_q)
    );

    xmem_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MC_W(MC_W)) u_drive (
        .ext     (state == ACC_EXT),
        .we      (we_q),
        .mc      (mc),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .ad_oe   (ad_oe),
        .ad_out  (ad_out),
        .addr_hi (addr_hi)
    );
endmodule

// File: rtl/xmem_stretch_chk.sv
// Protocol checker for the access sequencer, bound to every instance.
module xmem_stretch_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic rd_n,
    input logic wr_n,
    input logic ad_oe,
    input logic done
);
    // R3
    ale_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n && ad_oe));
    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    // R4
    wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> ad_oe);
    // R5
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    rd_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> done);
    // R4
    wr_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> done);
endmodule

bind xmem_stretch_ctrl xmem_stretch_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ale   (ale),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .ad_oe (ad_oe),
    .done  (done)
);

// File: tb/tb_xmem_stretch_ctrl.sv
// Bench: behavioural reference model compared with the design every clock.
module tb_xmem_stretch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [2:0]  stretch = '0;
    logic        ram_en = 1'b0, wait_en = 1'b0, wait_in = 1'b0;
    logic [7:0]  ad_in = '0;
    logic        ale, rd_n, wr_n, ad_oe, done;
    logic [7:0]  ad_out, addr_hi, rdata;

    always #2.5 clk = ~clk;

    xmem_stretch_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .stretch(stretch),
        .ram_en(ram_en), .wait_en(wait_en), .wait_in(wait_in), .ad_in(ad_in),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
        .addr_hi(addr_hi), .rdata(rdata), .done(done)
    );

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Reference model state
    bit          m_busy = 0, m_int = 0, m_we = 0, m_done = 0;
    int          m_k = 0, m_n = 0;
    logic [15:0] m_addr = '0;
    logic [7:0]  m_wd = '0, m_rd = '0;
    logic [7:0]  mref [0:1023];

    // Model update on each clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_rd = '0; m_k = 0;
        end else if (!m_busy) begin
            m_done = 0;
            if (req) begin
                m_busy = 1; m_k = 0; m_addr = req_addr; m_we = req_we;
                m_wd = req_wdata;
                m_int = ram_en && (req_addr < 16'h0400);
                m_n = m_int ? 2 : int'(stretch) + 2;
            end
        end else begin
            m_done = 0;
            if (m_k == 4 * m_n - 1) begin
                if (!m_int && wait_en && wait_in) begin
                    m_n++; m_k++;
                end else begin
                    m_busy = 0; m_done = 1;
                    if (m_int && m_we) mref[m_addr[9:0]] = m_wd;
                    if (!m_we) m_rd = m_int ? mref[m_addr[9:0]] : ad_in;
                end
            end else m_k++;
        end
    end

    // Compare every output on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit ext;
            logic [7:0] e_ad;
            ext = m_busy && !m_int;
            e_ad = !ext ? 8'h00 : (m_k < 4) ? m_addr[7:0] : (m_we ? m_wd : 8'h00);
            chk(ale == (ext && m_k < 4), tag, "ale", ale, ext && m_k < 4);
            chk(rd_n == !(ext && m_k >= 4 && !m_we), tag, "rd_n", rd_n, !(ext && m_k >= 4 && !m_we));
            chk(wr_n == !(ext && m_k >= 4 && m_we), tag, "wr_n", wr_n, !(ext && m_k >= 4 && m_we));
            chk(ad_oe == (ext && (m_k < 4 || m_we)), tag, "ad_oe", ad_oe, ext && (m_k < 4 || m_we));
            chk(ad_out == e_ad, tag, "ad_out", ad_out, e_ad);
            chk(addr_hi == (ext ? m_addr[15:8] : 8'h00), tag, "addr_hi", addr_hi, ext ? m_addr[15:8] : 0);
            chk(done == m_done, tag, "done", done, m_done);
            chk(rdata == m_rd, tag, "rdata", rdata, m_rd);
        end
    end

    // Issue one access, count falling edges to done, check latency.
    task automatic access(input logic [15:0] a, input bit w, input logic [7:0] d,
                          input logic [7:0] bus, input int exp_lat,
                          input int release_at);
        int lat;
        @(negedge clk);
        req = 1; req_addr = a; req_we = w; req_wdata = d; ad_in = bus;
        @(negedge clk);
        req = 0; req_addr = 16'hFFFF; req_wdata = 8'h99;
        lat = 1;
        while (!done && lat < 200) begin
            @(negedge clk);
            lat++;
            if (lat == release_at) wait_in = 0;
        end
        chk(lat == exp_lat, tag, "latency", lat, exp_lat);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); cyc++;
            if (cyc > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected 100000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ale == 0 && ad_oe == 0 && done == 0, "R1", "ale/oe/done", {ale, ad_oe, done}, 0);
        chk(rd_n && wr_n, "R1", "strobes", {rd_n, wr_n}, 3);
        chk(rdata == 0 && ad_out == 0 && addr_hi == 0, "R1", "data", rdata, 0);
        rst_n = 1;

        tag = "R4"; stretch = 0;                    // R4, R2 shortest
        access(16'h1234, 1, 8'hA5, 8'h00, 9, -1);
        tag = "R5"; stretch = 7;                    // R5, R2 longest
        access(16'hBEEF, 0, 8'h00, 8'h3C, 37, -1);
        chk(rdata == 8'h3C, "R5", "rdata", rdata, 8'h3C);
        tag = "R2"; stretch = 3;
        access(16'h8001, 1, 8'h5A, 8'h00, 21, -1);
        tag = "R3"; stretch = 1;
        access(16'hC3A7, 0, 8'h00, 8'hE1, 13, -1);

        tag = "R6"; stretch = 0; wait_en = 1; wait_in = 1;
        access(16'h4000, 0, 8'h00, 8'h77, 21, 19);
        tag = "R7"; wait_en = 0; wait_in = 1;
        access(16'h4001, 1, 8'h12, 8'h00, 9, -1);
        wait_in = 0;

        tag = "R8"; ram_en = 1; stretch = 6; wait_en = 1; wait_in = 1;
        access(16'h0010, 1, 8'h55, 8'h00, 9, -1);
        access(16'h0010, 0, 8'h00, 8'hEE, 9, -1);
        chk(rdata == 8'h55, "R8", "ram readback", rdata, 8'h55);
        wait_en = 0; wait_in = 0;

        tag = "R9"; ram_en = 0; stretch = 0;
        access(16'h0010, 1, 8'hAA, 8'h00, 9, -1);
        ram_en = 1;
        access(16'h0010, 0, 8'h00, 8'h11, 9, -1);
        chk(rdata == 8'h55, "R9", "ram untouched", rdata, 8'h55);

        tag = "R10"; stretch = 5;
        access(16'h03FF, 1, 8'h3F, 8'h00, 9, -1);
        access(16'h0400, 1, 8'h40, 8'h00, 29, -1);
        access(16'h03FF, 0, 8'h00, 8'h00, 9, -1);
        chk(rdata == 8'h3F, "R10", "top of window", rdata, 8'h3F);

        // R11: request held through a busy access, inputs change mid-access
        tag = "R11"; stretch = 1;
        @(negedge clk);
        req = 1; req_we = 0; req_addr = 16'h2000; ad_in = 8'h9D;
        repeat (3) @(negedge clk);
        req_addr = 16'h3011; req_we = 1; req_wdata = 8'h6B;
        while (!done) @(negedge clk);
        chk(rdata == 8'h9D, "R11", "first read kept", rdata, 8'h9D);
        @(negedge clk);
        req = 0;
        chk(ale == 1 && addr_hi == 8'h30, "R11", "second accept", {ale, addr_hi}, 9'h130);
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule